// File: doc/BRIEF.md
# Prescaled Compare/Capture PWM Timer

A general-purpose timer built around a 16-bit up-counter. A power-of-two prescaler, picked by a 3-bit select field, gives the counting rate. Software drives the block through a small word-wide register bus. Through it, software starts and stops the counter, loads the count, programs two compare values and the mode, and reads the capture registers. It also enables interrupt sources and clears pending flags.

Three ways of counting come out of the mode register. The counter can run free and wrap at the top of its range. It can return to zero after a match on the second compare value, which gives a periodic time base. It can also drive a PWM pin, where each compare channel carries a two-bit action that sets, clears or toggles the pin when its match fires. A rising edge on a capture input copies the running count into that input's capture register. Every event sets a sticky status bit. The interrupt line is high while any enabled status bit is set.

Top module: `timer_cc16`

## Requirements
- R1: After reset every register reads zero, and `pwm_out` and `irq` are low.
- R2: The counter moves on by one every 2^(n+1) clocks while the run bit (address 0 bit 0) is 1, where n is the select field (address 0 bits [4:2]). Select value 7 divides by 128, the same as 6. With the run bit 0 the count holds. After a run write at edge E0 the count reads floor(k/2^(n+1)) after edge Ek.
- R3: Writing a new select value while the run bit stays 1 neither clears the count nor restarts the prescaler phase.
- R4: With the period-reset bit clear, the count wraps from 0xFFFF to 0 and sets status bit 2 (overflow).
- R5: With the period-reset bit (address 4 bit 14) set, a tick taken while the count equals compare 1 returns the count to 0. Such a tick sets status bit 1, and a tick taken while the count equals compare 0 sets status bit 0.
- R6: With the PWM bit (address 4 bit 15) set, a compare-0 match applies the action in bits [11:10] to `pwm_out` and a compare-1 match applies the action in bits [13:12]. Compare 1 is applied after compare 0. The codes are 00 none, 01 set, 10 clear and 11 toggle. With the PWM bit clear, `pwm_out` is forced low one clock later.
- R7: A rising edge on `cap_in[i]` passes two synchroniser flops. It then latches the count into capture register i (address 8+i) and sets status bit 3+i. The latched value is the count two edges after the input rose, and it is readable three edges after. A falling edge does nothing.
- R8: Status (address 6) is write-one-to-clear. Writing 0 to a bit leaves it unchanged, and an event in the same cycle as a clear leaves the bit set.
- R9: `irq` is high exactly while some status bit is set whose bit in the enable register (address 5) is also set.
- R10: Address map: 0 control, 1 count, 2 compare 0, 3 compare 1, 4 mode, 5 enable, 6 status, 8+i capture i. A count write overrides a tick in the same cycle. Compare and capture registers read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high together with bus_sel |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from bus_addr |
| cap_in | input | 2 | Asynchronous capture inputs |
| pwm_out | output | 1 | PWM pin |
| irq | output | 1 | Interrupt request |

## Verification
The prescaler is swept over all eight select values. At each one the count is read one cycle before and exactly at the third step boundary, and again after a long run. This separates an off-by-one in the tick phase from a wrong divide ratio, and shows that select 7 saturates. The periodic mode is read on every cycle over several periods, which checks the return point against the compare-1 value. PWM is checked cycle by cycle with a set/clear pair and with a toggle/toggle pair, so a wrong code decode or a wrong match edge shows up as a pin/count mismatch. Capture is driven at known cycles on each channel, which pins down the synchroniser latency and the channel steering. A falling edge confirms that it does nothing.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_SET  = 2'b01,
    ACT_CLR  = 2'b10,
    ACT_TOG  = 2'b11
  } pin_act_e;

  // register word addresses
  localparam int unsigned A_CTRL     = 0;
  localparam int unsigned A_COUNT    = 1;
  localparam int unsigned A_CMP0     = 2;
  localparam int unsigned A_CMP1     = 3;
  localparam int unsigned A_MODE     = 4;
  localparam int unsigned A_IEN      = 5;
  localparam int unsigned A_STAT     = 6;
  localparam int unsigned A_CAP_BASE = 8;

  // control and mode bit positions
  localparam int unsigned B_RUN  = 0;
  localparam int unsigned B_SEL  = 2;
  localparam int unsigned B_PWM  = 15;
  localparam int unsigned B_TC   = 14;
  localparam int unsigned B_ACT1 = 12;
  localparam int unsigned B_ACT0 = 10;

  // status bit positions
  localparam int unsigned S_CMP0 = 0;
  localparam int unsigned S_CMP1 = 1;
  localparam int unsigned S_OVF  = 2;
  localparam int unsigned S_CAP  = 3;

  function automatic logic apply_act(input pin_act_e a, input logic v);
    case (a)
      ACT_SET: return 1'b1;
      ACT_CLR: return 1'b0;
      ACT_TOG: return ~v;
      default: return v;
    endcase
  endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int unsigned SEL_W   = 3,
  parameter int unsigned DIV_LOG = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [DIV_LOG-1:0] div_q, div_d, mask;
  int eff;

  always_comb begin
    eff = (int'(sel) > int'(DIV_LOG) - 1) ? int'(DIV_LOG) - 1 : int'(sel);
    for (int i = 0; i < int'(DIV_LOG); i++) mask[i] = (i <= eff);
    tick  = run && ((div_q & mask) == mask);
    div_d = run ? div_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  // R2: no tick while stopped, and the phase restarts from zero
  a_r2_stop_phase: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (div_q == '0));

endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          tc_en,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_val,
  input  logic [CW-1:0] cmp0,
  input  logic [CW-1:0] cmp1,
  output logic [CW-1:0] cnt,
  output logic          hit0,
  output logic          hit1,
  output logic          ovf
);
  logic [CW-1:0] cnt_d;
  logic          per_clr;

  always_comb begin
    hit0    = tick && (cnt == cmp0);
    hit1    = tick && (cnt == cmp1);
    per_clr = tc_en && hit1;
    ovf     = tick && (cnt == '1) && !per_clr;
    cnt_d   = cnt;
    if (wr_en)        cnt_d = wr_val;
    else if (per_clr) cnt_d = '0;
    else if (tick)    cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> $stable(cnt));
  a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !wr_en) |=> (cnt == '0));
  a_r5_period_return: assert property (@(posedge clk) disable iff (!rst_n)
    (hit1 && tc_en && !wr_en) |=> (cnt == '0));
  a_r10_sw_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cnt == $past(wr_val)));

endmodule

// File: rtl/tmr_capture.sv
module tmr_capture #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_pin,
  input  logic [CW-1:0] cnt,
  input  logic          sw_we,
  input  logic [CW-1:0] sw_val,
  output logic [CW-1:0] cap,
  output logic          ev
);
  logic          s1_q, s2_q, s3_q;
  logic [CW-1:0] cap_d;

  always_comb begin
    ev    = s2_q && !s3_q;
    cap_d = cap;
    if (ev)         cap_d = cnt;
    else if (sw_we) cap_d = sw_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
      cap  <= '0;
    end else begin
      s1_q <= cap_pin;
      s2_q <= s1_q;
      s3_q <= s2_q;
      cap  <= cap_d;
    end
  end

  // R7: a detected edge stores the count seen in that cycle
  a_r7_latch: assert property (@(posedge clk) disable iff (!rst_n)
    ev |=> (cap == $past(cnt)));

endmodule

// File: rtl/timer_cc16.sv
module timer_cc16
  import tmr_pkg::*;
#(
  parameter int unsigned CW      = 16,
  parameter int unsigned NCAP    = 2,
  parameter int unsigned SEL_W   = 3,
  parameter int unsigned DIV_LOG = 7,
  parameter int unsigned AW      = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [CW-1:0]   bus_wdata,
  output logic [CW-1:0]   bus_rdata,
  input  logic [NCAP-1:0] cap_in,
  output logic            pwm_out,
  output logic            irq
);
  localparam int unsigned SW = S_CAP + NCAP;

  logic             run_q, run_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic [CW-1:0]    cmp0_q, cmp0_d, cmp1_q, cmp1_d;
  logic             pwm_q, pwm_d, tc_q, tc_d;
  pin_act_e         act0_q, act0_d, act1_q, act1_d;
  logic [SW-1:0]    ien_q, ien_d, stat_q, stat_d, ev;
  logic             pin_d;

  logic             we, wr_ctrl, wr_cnt, wr_cmp0, wr_cmp1, wr_mode, wr_ien, wr_stat;
  logic             tick, hit0, hit1, ovf;
  logic [CW-1:0]    cnt;
  logic [NCAP-1:0]  cap_ev, cap_we;
  logic [CW-1:0]    cap_q [NCAP];

  assign we      = bus_sel && bus_we;
  assign wr_ctrl = we && (bus_addr == AW'(A_CTRL));
  assign wr_cnt  = we && (bus_addr == AW'(A_COUNT));
  assign wr_cmp0 = we && (bus_addr == AW'(A_CMP0));
  assign wr_cmp1 = we && (bus_addr == AW'(A_CMP1));
  assign wr_mode = we && (bus_addr == AW'(A_MODE));
  assign wr_ien  = we && (bus_addr == AW'(A_IEN));
  assign wr_stat = we && (bus_addr == AW'(A_STAT));

  tmr_prescale #(.SEL_W(SEL_W), .DIV_LOG(DIV_LOG)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run_q), .sel(sel_q), .tick(tick));

  tmr_count #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .tc_en(tc_q),
    .wr_en(wr_cnt), .wr_val(bus_wdata), .cmp0(cmp0_q), .cmp1(cmp1_q),
    .cnt(cnt), .hit0(hit0), .hit1(hit1), .ovf(ovf));

  for (genvar i = 0; i < int'(NCAP); i++) begin : g_cap
    assign cap_we[i] = we && (bus_addr == AW'(A_CAP_BASE + i));
    tmr_capture #(.CW(CW)) u_cap (
      .clk(clk), .rst_n(rst_n), .cap_pin(cap_in[i]), .cnt(cnt),
      .sw_we(cap_we[i]), .sw_val(bus_wdata), .cap(cap_q[i]), .ev(cap_ev[i]));
  end

  // next-state for software registers, status and pin
  always_comb begin
    run_d  = wr_ctrl ? bus_wdata[B_RUN] : run_q;
    sel_d  = wr_ctrl ? bus_wdata[B_SEL +: SEL_W] : sel_q;
    cmp0_d = wr_cmp0 ? bus_wdata : cmp0_q;
    cmp1_d = wr_cmp1 ? bus_wdata : cmp1_q;
    pwm_d  = wr_mode ? bus_wdata[B_PWM] : pwm_q;
    tc_d   = wr_mode ? bus_wdata[B_TC]  : tc_q;
    act1_d = wr_mode ? pin_act_e'(bus_wdata[B_ACT1 +: 2]) : act1_q;
    act0_d = wr_mode ? pin_act_e'(bus_wdata[B_ACT0 +: 2]) : act0_q;
    ien_d  = wr_ien  ? bus_wdata[SW-1:0] : ien_q;

    ev         = '0;
    ev[S_CMP0] = hit0;
    ev[S_CMP1] = hit1;
    ev[S_OVF]  = ovf;
    ev[S_CAP +: NCAP] = cap_ev;
    stat_d = (stat_q & ~(wr_stat ? bus_wdata[SW-1:0] : '0)) | ev;

    pin_d = pwm_out;
    if (hit0) pin_d = apply_act(act0_q, pin_d);
    if (hit1) pin_d = apply_act(act1_q, pin_d);
    if (!pwm_q) pin_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      sel_q   <= '0;
      cmp0_q  <= '0;
      cmp1_q  <= '0;
      pwm_q   <= 1'b0;
      tc_q    <= 1'b0;
      act0_q  <= ACT_NONE;
      act1_q  <= ACT_NONE;
      ien_q   <= '0;
      stat_q  <= '0;
      pwm_out <= 1'b0;
    end else begin
      run_q   <= run_d;
      sel_q   <= sel_d;
      cmp0_q  <= cmp0_d;
      cmp1_q  <= cmp1_d;
      pwm_q   <= pwm_d;
      tc_q    <= tc_d;
      act0_q  <= act0_d;
      act1_q  <= act1_d;
      ien_q   <= ien_d;
      stat_q  <= stat_d;
      pwm_out <= pin_d;
    end
  end

  assign irq = |(stat_q & ien_q);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      AW'(A_CTRL): begin
        bus_rdata[B_RUN] = run_q;
        bus_rdata[B_SEL +: SEL_W] = sel_q;
      end
      AW'(A_COUNT): bus_rdata = cnt;
      AW'(A_CMP0):  bus_rdata = cmp0_q;
      AW'(A_CMP1):  bus_rdata = cmp1_q;
      AW'(A_MODE): begin
        bus_rdata[B_PWM] = pwm_q;
        bus_rdata[B_TC]  = tc_q;
        bus_rdata[B_ACT1 +: 2] = act1_q;
        bus_rdata[B_ACT0 +: 2] = act0_q;
      end
      AW'(A_IEN):  bus_rdata[SW-1:0] = ien_q;
      AW'(A_STAT): bus_rdata[SW-1:0] = stat_q;
      default: begin
        for (int i = 0; i < int'(NCAP); i++)
          if (bus_addr == AW'(A_CAP_BASE + i)) bus_rdata = cap_q[i];
      end
    endcase
  end

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ev != '0) |=> ((stat_q & $past(ev)) == $past(ev)));
  a_r8_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && ev == '0) |=> ((stat_q & $past(bus_wdata[SW-1:0])) == '0));
  a_r6_pin_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_q |=> !pwm_out);

endmodule

// File: tb/tb_timer_cc16.sv
module tb_timer_cc16;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_we;
  logic [3:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic [1:0]  cap_in;
  logic        pwm_out, irq;
  int checks = 0;
  int fails  = 0;
  logic [15:0] v;

  always #10 clk = ~clk;

  timer_cc16 dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cap_in(cap_in), .pwm_out(pwm_out), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic restart(input int sel);
    wr(4'd0, 16'(sel << 2));
    wr(4'd1, 16'h0000);
    wr(4'd0, 16'((sel << 2) | 1));
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bus_sel = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0; cap_in = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 10; a++) begin
      rd(4'(a), v);
      chk($sformatf("R1 reg %0d", a), v, 0);
    end
    chk("R1 pwm_out", pwm_out, 0);
    chk("R1 irq", irq, 0);

    // R10 register access, R2 hold while stopped
    wr(4'd2, 16'hA5A5); rd(4'd2, v); chk("R10 cmp0", v, 16'hA5A5);
    wr(4'd3, 16'h5A5A); rd(4'd3, v); chk("R10 cmp1", v, 16'h5A5A);
    wr(4'd8, 16'h1234); rd(4'd8, v); chk("R10 cap0", v, 16'h1234);
    wr(4'd9, 16'h4321); rd(4'd9, v); chk("R10 cap1", v, 16'h4321);
    wr(4'd1, 16'h0100); rd(4'd1, v); chk("R10 count load", v, 16'h0100);
    repeat (5) @(negedge clk);
    rd(4'd1, v); chk("R2 stopped hold", v, 16'h0100);

    // R2 prescaler sweep
    for (int n = 0; n < 8; n++) begin
      int d;
      int ks [3];
      d = 2 << ((n > 6) ? 6 : n);
      ks[0] = 3 * d - 1; ks[1] = 3 * d; ks[2] = 300;
      for (int j = 0; j < 3; j++) begin
        restart(n);
        repeat (ks[j]) @(negedge clk);
        rd(4'd1, v);
        chk($sformatf("R2 sel=%0d k=%0d", n, ks[j]), v, 32'(ks[j] / d));
      end
    end

    // R3 select change while running
    restart(0);
    repeat (10) @(negedge clk);
    rd(4'd1, v); chk("R3 before change", v, 5);
    wr(4'd0, 16'((1 << 2) | 1));
    rd(4'd1, v); chk("R3 at change", v, 5);
    repeat (5) @(negedge clk);
    rd(4'd1, v); chk("R3 after change", v, 7);

    // R4 wrap and overflow flag
    wr(4'd0, 16'h0000);
    wr(4'd4, 16'h0000);
    wr(4'd2, 16'h8000); wr(4'd3, 16'h8001);
    wr(4'd1, 16'hFFFE);
    wr(4'd6, 16'hFFFF);
    wr(4'd0, 16'h0001);
    repeat (3) @(negedge clk);
    rd(4'd6, v); chk("R4 ovf not yet", v & 16'h4, 0);
    @(negedge clk);
    rd(4'd1, v); chk("R4 wrapped count", v, 0);
    rd(4'd6, v); chk("R4 ovf flag", v & 16'h4, 16'h4);

    // R9 irq masking, R8 write-one-to-clear
    wr(4'd0, 16'h0000);
    chk("R9 irq masked", irq, 0);
    wr(4'd5, 16'h0004);
    chk("R9 irq enabled", irq, 1);
    wr(4'd6, 16'h0003);
    rd(4'd6, v); chk("R8 zero bits keep", v & 16'h4, 16'h4);
    chk("R9 irq still", irq, 1);
    wr(4'd6, 16'h0004);
    rd(4'd6, v); chk("R8 cleared", v & 16'h4, 0);
    chk("R9 irq dropped", irq, 0);
    wr(4'd5, 16'h0000);

    // R5 periodic mode
    wr(4'd4, 16'h4000);
    wr(4'd3, 16'd4); wr(4'd2, 16'd2);
    wr(4'd1, 16'd0);
    wr(4'd6, 16'hFFFF);
    wr(4'd0, 16'h0001);
    for (int k = 1; k <= 30; k++) begin
      @(negedge clk);
      rd(4'd1, v);
      chk($sformatf("R5 periodic k=%0d", k), v, 32'((k / 2) % 5));
    end
    rd(4'd6, v); chk("R5 match flags", v & 16'h3, 16'h3);

    // R6 PWM set/clear
    wr(4'd0, 16'h0000);
    wr(4'd4, 16'h0000);
    chk("R6 idle pin", pwm_out, 0);
    wr(4'd1, 16'd0);
    wr(4'd2, 16'd2); wr(4'd3, 16'd7);
    wr(4'd4, 16'hE400);
    wr(4'd0, 16'h0001);
    for (int k = 1; k <= 40; k++) begin
      int c;
      @(negedge clk);
      c = (k / 2) % 8;
      chk($sformatf("R6 set/clear k=%0d", k), pwm_out, (c >= 3) ? 1 : 0);
    end

    // R6 PWM toggle/toggle
    wr(4'd0, 16'h0000);
    wr(4'd4, 16'h0000);
    wr(4'd1, 16'd0);
    wr(4'd2, 16'd1); wr(4'd3, 16'd3);
    wr(4'd4, 16'hFC00);
    wr(4'd0, 16'h0001);
    for (int k = 1; k <= 24; k++) begin
      int c;
      @(negedge clk);
      c = (k / 2) % 4;
      chk($sformatf("R6 toggle k=%0d", k), pwm_out, (c >= 2) ? 1 : 0);
    end
    wr(4'd4, 16'h0000);
    chk("R6 pwm off", pwm_out, 0);

    // R7 capture
    wr(4'd0, 16'h0000);
    wr(4'd2, 16'h8000); wr(4'd3, 16'h8001);
    wr(4'd1, 16'd0);
    wr(4'd6, 16'hFFFF);
    wr(4'd0, 16'h0001);
    repeat (9) @(negedge clk);
    cap_in[1] = 1'b1;
    repeat (3) @(negedge clk);
    rd(4'd9, v); chk("R7 cap1 value", v, 5);
    rd(4'd6, v); chk("R7 cap flags ch1 only", v & 16'h18, 16'h10);
    repeat (8) @(negedge clk);
    cap_in[0] = 1'b1;
    repeat (3) @(negedge clk);
    rd(4'd8, v); chk("R7 cap0 value", v, 11);
    rd(4'd6, v); chk("R7 cap0 flag", v & 16'h8, 16'h8);
    cap_in[1] = 1'b0;
    repeat (4) @(negedge clk);
    rd(4'd9, v); chk("R7 falling edge ignored", v, 5);

    finish_run();
  end
endmodule